// File: doc/BRIEF.md
# Buffered Configuration-Port Transfer Engine

This memory-mapped peripheral holds a word-organised staging buffer of 512 words of 32 bits and moves a programmed run of words between that buffer and a device configuration port, in either direction. Software reaches the buffer through the lower half of the block's address window. The byte address of a buffer word is its word index shifted left by two, and each bus word is stored and returned unchanged.

To run a transfer, software programs a byte length and a starting buffer word index. It then writes the direction register: 0 streams buffer words out to the port, and 1 captures port words into the buffer. A status word gives a done flag, four constant-one bits and four live flags from the port. Any write to the status word stops the engine at once. The port side is a plain word-wide write strobe and read strobe, paced by a busy input.

Top module: `cfgport_xfer_engine`

## Requirements
- R1: A bus write with `busAddr[11]`=0 stores `busWdata` in buffer word `busAddr[10:2]`, and a read of that address returns it in the same cycle.
- R2: The length register (`busAddr[11]`=1, `busAddr[3:2]`=0) and the start-index register (`busAddr[3:2]`=1) hold all 32 written bits and read them back.
- R3: A write of 0 in bit 0 to the direction register (`busAddr[3:2]`=2) while idle puts buffer words on `portWdata` with `portWrStb`, starting at the start index and going up one word at a time.
- R4: A write of 1 to the direction register while idle stores `portRdata` into the buffer at each `portRdStb` cycle, starting at the start index and going up.
- R5: A read of the status word (`busAddr[3:2]`=3) returns done in bit 0 and ones in bits 4:1. Bits 8:5 hold `portFlags[3:0]` (abort-in, read-in-progress, aligned, configuration error), and all higher bits are 0.
- R6: Done is 1 after reset. It reads 0 in the cycle after a start that moves one or more words, and it returns to 1 after the last word moves.
- R7: No strobe is issued in a cycle where `portBusy` is high. The transfer resumes when `portBusy` goes low, and no word is lost.
- R8: A write to the direction register while a transfer runs has no effect on direction or word count.
- R9: Any write to the status word ends a running transfer. No strobe is issued in that cycle or after it, and done reads 1.
- R10: The number of words moved is the lesser of length/4 and 512 minus the start index, and it is 0 when the start index is 512 or more.
- R11: A start with a word count of zero leaves done at 1 and issues no strobe.
- R12: `portWrStb` and `portRdStb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address inside the block window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| portWrStb | output | 1 | Word presented to the port |
| portWdata | output | 32 | Word to the port |
| portRdStb | output | 1 | Word taken from the port |
| portRdata | input | 32 | Word from the port, valid during portRdStb |
| portBusy | input | 1 | Port stall |
| portFlags | input | 4 | Live port status flags |

## Verification
Two events can land on the same clock edge: a status-word write that aborts the engine, and a word move that the engine would make in that cycle because the port is not busy. The bench provokes this by aborting a long configuration with busy held low. It reads the port write count just before the abort edge and again just after it. The two counts must be equal, done must read 1, and the count must then stay frozen.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadAddr;   // latch start index into the address counter
    logic stepWord;   // one word moves this cycle
    logic dirRead;    // 1 = port to buffer
  } xfer_ctl_t;

  typedef enum logic [1:0] {
    REG_LEN  = 2'd0,
    REG_IDX  = 2'd1,
    REG_DIR  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              startVal,
  input  logic              abortReq,
  input  logic [DATA_W-1:0] lenReg,
  input  logic [DATA_W-1:0] idxReg,
  input  logic              portBusy,
  output xfer_ctl_t         ctl,
  output logic              done,
  output logic              portWrStb,
  output logic              portRdStb
);
  localparam int CNT_W = $clog2(BUF_WORDS + 1);

  logic              running;
  logic              dirRead;
  logic [CNT_W-1:0]  remain;
  logic [DATA_W-1:0] reqWords;
  logic [DATA_W-1:0] room;
  logic [CNT_W-1:0]  grant;
  logic              move;
  logic              launch;

  always_comb begin
    reqWords = lenReg >> 2;
    room     = (idxReg < DATA_W'(BUF_WORDS)) ? (DATA_W'(BUF_WORDS) - idxReg) : '0;
    grant    = CNT_W'((reqWords < room) ? reqWords : room);
    launch   = !running && startReq && !abortReq && (grant != '0);
    move     = running && !portBusy && !abortReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      dirRead <= 1'b0;
      remain  <= '0;
    end else if (abortReq) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (launch) begin
      running <= 1'b1;
      dirRead <= startVal;
      remain  <= grant;
    end else if (move) begin
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) running <= 1'b0;
    end
  end

  always_comb begin
    ctl.loadAddr = launch;
    ctl.stepWord = move;
    ctl.dirRead  = dirRead;
    done         = !running;
    portWrStb    = move && !dirRead;
    portRdStb    = move && dirRead;
  end

  // R7
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    portBusy |-> !(portWrStb || portRdStb));
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({portWrStb, portRdStb}));
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> done);
  // R6
  done_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(startReq));
  // R8
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && startReq) |=> (ctl.dirRead == $past(ctl.dirRead)));
  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && startReq && (lenReg[DATA_W-1:2] == '0)) |=> done);
  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (remain <= CNT_W'(BUF_WORDS)));
endmodule

// File: rtl/cfgx_datapath.sv
module cfgx_datapath
  import cfgx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 512,
  parameter int ADDR_W    = 12,
  parameter int FLAG_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  xfer_ctl_t         ctl,
  input  logic              done,
  input  logic [FLAG_W-1:0] portFlags,
  input  logic [DATA_W-1:0] portRdata,
  output logic [DATA_W-1:0] portWdata,
  output logic [DATA_W-1:0] lenReg,
  output logic [DATA_W-1:0] idxReg,
  output logic              startReq,
  output logic              startVal,
  output logic              abortReq
);
  localparam int IDX_W    = $clog2(BUF_WORDS);
  localparam int ONES_LSB = 1;
  localparam int ONES_W   = 4;
  localparam int FLAG_LSB = ONES_LSB + ONES_W;

  logic              regWin;
  reg_sel_e          regSel;
  logic [IDX_W-1:0]  bufIdx;
  logic [IDX_W-1:0]  addrQ;
  logic [DATA_W-1:0] mem [BUF_WORDS];
  logic [DATA_W-1:0] statWord;
  logic              busWrBuf;
  logic              portWrBuf;

  always_comb begin
    regWin    = busAddr[ADDR_W-1];
    regSel    = reg_sel_e'(busAddr[3:2]);
    bufIdx    = busAddr[IDX_W+1:2];
    startReq  = busSel && busWe && regWin && (regSel == REG_DIR);
    startVal  = busWdata[0];
    abortReq  = busSel && busWe && regWin && (regSel == REG_STAT);
    busWrBuf  = busSel && busWe && !regWin;
    portWrBuf = ctl.stepWord && ctl.dirRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0;
      idxReg <= '0;
    end else if (busSel && busWe && regWin) begin
      if (regSel == REG_LEN) lenReg <= busWdata;
      if (regSel == REG_IDX) idxReg <= busWdata;
    end
  end

  // address generator
  always_ff @(posedge clk) begin
    if (!rstN)             addrQ <= '0;
    else if (ctl.loadAddr) addrQ <= idxReg[IDX_W-1:0];
    else if (ctl.stepWord) addrQ <= addrQ + 1'b1;
  end

  // single write port: a readback word wins over a bus write
  always_ff @(posedge clk) begin
    if (portWrBuf)     mem[addrQ]  <= portRdata;
    else if (busWrBuf) mem[bufIdx] <= busWdata;
  end

  always_comb begin
    statWord                          = '0;
    statWord[0]                       = done;
    statWord[ONES_LSB +: ONES_W]      = '1;
    statWord[FLAG_LSB +: FLAG_W]      = portFlags;
    portWdata                         = mem[addrQ];
    busRdata                          = '0;
    if (!regWin) busRdata = mem[bufIdx];
    else begin
      case (regSel)
        REG_LEN:  busRdata = lenReg;
        REG_IDX:  busRdata = idxReg;
        REG_STAT: busRdata = statWord;
        default:  busRdata = '0;
      endcase
    end
  end

  // R1
  buf_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrBuf && !portWrBuf) |=> (mem[$past(bufIdx)] == $past(busWdata)));
  // R4
  rb_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    portWrBuf |=> (mem[$past(addrQ)] == $past(portRdata)));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepWord && !ctl.loadAddr) |=> (addrQ == $past(addrQ) + 1'b1));
endmodule

// File: rtl/cfgport_xfer_engine.sv
module cfgport_xfer_engine
  import cfgx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 512,
  parameter int ADDR_W    = 12,
  parameter int FLAG_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              portWrStb,
  output logic [DATA_W-1:0] portWdata,
  output logic              portRdStb,
  input  logic [DATA_W-1:0] portRdata,
  input  logic              portBusy,
  input  logic [FLAG_W-1:0] portFlags
);
  xfer_ctl_t         ctl;
  logic              done;
  logic [DATA_W-1:0] lenReg;
  logic [DATA_W-1:0] idxReg;
  logic              startReq;
  logic              startVal;
  logic              abortReq;

  cfgx_ctrl #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startVal(startVal),
    .abortReq(abortReq), .lenReg(lenReg), .idxReg(idxReg),
    .portBusy(portBusy), .ctl(ctl), .done(done),
    .portWrStb(portWrStb), .portRdStb(portRdStb)
  );

  cfgx_datapath #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .ADDR_W(ADDR_W),
                  .FLAG_W(FLAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ctl(ctl), .done(done), .portFlags(portFlags), .portRdata(portRdata),
    .portWdata(portWdata), .lenReg(lenReg), .idxReg(idxReg),
    .startReq(startReq), .startVal(startVal), .abortReq(abortReq)
  );
endmodule

// File: tb/cfgport_xfer_engine_bench.sv
module cfgport_xfer_engine_bench;
  localparam logic [11:0] A_LEN = 12'h800, A_IDX = 12'h804,
                          A_DIR = 12'h808, A_STAT = 12'h80C;

  logic clk = 0, rstN = 0, busSel = 0, busWe = 0, portBusy = 0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, portWdata, portRdata;
  logic portWrStb, portRdStb;
  logic [3:0] portFlags = '0;

  int nChk = 0, nBad = 0;
  int busyMode = 0;
  int wrCount = 0, rdCount = 0;
  logic [31:0] wrLog [4096];
  logic [31:0] model [512];

  always #4 clk = ~clk;

  cfgport_xfer_engine u_cfgport_xfer_engine (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .portWrStb(portWrStb),
    .portWdata(portWdata), .portRdStb(portRdStb), .portRdata(portRdata),
    .portBusy(portBusy), .portFlags(portFlags));

  function automatic logic [31:0] rdPat(int k);
    return 32'hC0DE_0000 ^ (k * 32'h0001_0003);
  endfunction

  function automatic int expWords(int len, int idx);
    int req = len / 4;
    int room = (idx < 512) ? 512 - idx : 0;
    return (req < room) ? req : room;
  endfunction

  assign portRdata = rdPat(rdCount);

  always @(posedge clk) begin
    if (portWrStb) begin
      if (wrCount < 4096) wrLog[wrCount] <= portWdata;
      wrCount <= wrCount + 1;
    end
    if (portRdStb) rdCount <= rdCount + 1;
  end

  always @(negedge clk)
    portBusy = (busyMode == 2) ? 1'b1 : (busyMode == 1) ? ($urandom % 3 == 0) : 1'b0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWe = 0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic waitDone();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      busRead(A_STAT, s);
      if (s[0]) return;
    end
  endtask

  task automatic runXfer(int idx, int words, bit rd, string tag);
    logic [31:0] s, v;
    int wb = wrCount, rb = rdCount, n = expWords(words * 4, idx);
    busWrite(A_LEN, words * 4);
    busWrite(A_IDX, idx);
    busWrite(A_DIR, {31'd0, rd});
    busRead(A_STAT, s);
    // R6 / R11: done low right after a start only when words move
    check(s[0] == (n == 0), {tag, " R6 done after start"}, {31'd0, s[0]}, (n == 0));
    waitDone();
    // R10 count of words moved
    check((rd ? rdCount - rb : wrCount - wb) == n, {tag, " R10 moved"},
          rd ? rdCount - rb : wrCount - wb, n);
    check((rd ? wrCount - wb : rdCount - rb) == 0, {tag, " R12 other strobe"}, 0, 0);
    for (int k = 0; k < n; k++) begin
      if (rd) begin
        model[idx + k] = rdPat(rb + k);
        busRead(12'((idx + k) << 2), v);
        check(v == model[idx + k], {tag, " R4 readback word"}, v, model[idx + k]);
      end else begin
        check(wrLog[wb + k] == model[idx + k], {tag, " R3 config word"},
              wrLog[wb + k], model[idx + k]);
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n0, n1;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1;

    busRead(A_STAT, v);
    check(v == 32'h1F, "R5 R6 reset status", v, 32'h1F);

    busWrite(A_LEN, 32'hDEAD_BEEC); busWrite(A_IDX, 32'h1234_5678);
    busRead(A_LEN, v); check(v == 32'hDEAD_BEEC, "R2 length", v, 32'hDEAD_BEEC);
    busRead(A_IDX, v); check(v == 32'h1234_5678, "R2 index", v, 32'h1234_5678);

    for (int i = 0; i < 512; i++) begin
      model[i] = $urandom;
      busWrite(12'(i << 2), model[i]);
    end
    for (int i = 0; i < 512; i += 37) begin
      busRead(12'(i << 2), v);
      check(v == model[i], "R1 buffer readback", v, model[i]);
    end
    busRead(12'(511 << 2), v);
    check(v == model[511], "R1 last word", v, model[511]);

    portFlags = 4'b1010;
    busRead(A_STAT, v); check(v == 32'h15F, "R5 flags", v, 32'h15F);
    portFlags = 4'b0101;
    busRead(A_STAT, v); check(v == 32'h0BF, "R5 flags", v, 32'h0BF);
    portFlags = 4'b0000;

    busyMode = 0; runXfer(5, 10, 0, "dir0");
    busyMode = 1; runXfer(40, 25, 0, "dir0 busy");
    busyMode = 1; runXfer(100, 20, 1, "dir1 busy");
    busyMode = 0; runXfer(500, 40, 0, "R10 clamp");
    runXfer(600, 8, 1, "R10 beyond");
    runXfer(3, 0, 0, "R11 zero");
    runXfer(511, 1, 1, "edge word");

    // R7: stall with busy held high
    busyMode = 2; n0 = wrCount;
    busWrite(A_LEN, 20); busWrite(A_IDX, 0); busWrite(A_DIR, 0);
    repeat (10) @(negedge clk);
    check(wrCount == n0, "R7 no strobe while busy", wrCount - n0, 0);
    busRead(A_STAT, v); check(v[0] == 0, "R7 still running", v[0], 0);
    busyMode = 0; waitDone();
    check(wrCount - n0 == 5, "R7 resumes", wrCount - n0, 5);
    for (int k = 0; k < 5; k++)
      check(wrLog[n0 + k] == model[k], "R7 word", wrLog[n0 + k], model[k]);

    // R8: direction write while running
    n0 = wrCount; n1 = rdCount;
    busWrite(A_LEN, 120); busWrite(A_IDX, 200); busWrite(A_DIR, 0);
    repeat (3) @(negedge clk);
    busWrite(A_DIR, 1);
    waitDone();
    check(wrCount - n0 == 30, "R8 count kept", wrCount - n0, 30);
    check(rdCount == n1, "R8 no readback", rdCount - n1, 0);

    // R9: abort on the same edge as a move
    busWrite(A_LEN, 800); busWrite(A_IDX, 0); busWrite(A_DIR, 0);
    repeat (4) @(negedge clk);
    n0 = wrCount;
    busSel = 1; busWe = 1; busAddr = A_STAT; busWdata = 32'h0000_FEFE;
    @(posedge clk); #1;
    busSel = 0; busWe = 0;
    n1 = wrCount;
    check(n1 == n0, "R9 no move on abort edge", n1 - n0, 0);
    busRead(A_STAT, v); check(v[0] == 1, "R9 done after abort", v[0], 1);
    repeat (10) @(negedge clk);
    check(wrCount == n1, "R9 frozen", wrCount - n1, 0);

    // random mix
    busyMode = 1;
    for (int r = 0; r < 8; r++)
      runXfer($urandom % 530, $urandom % 40, 1'($urandom % 2), "random");

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule